// File: doc/BRIEF.md
# Notification-to-Interrupt Delivery Unit with Message Vector Table

This block turns notifications from an address-translation unit into interrupts. Each notification arrives as a one-cycle strobe with a vector index. A plain control input selects how the interrupt is delivered. In wired mode the block raises one of four dedicated interrupt lines for a single cycle. In message mode it sends one 32-bit memory write to a master port. The target address and the payload of that write come from a software-programmed table. The table has one entry per vector.

Software reaches the table and a read-only pending-bit array through a register port with request and acknowledge. That port accepts 4-byte and 8-byte accesses, and each is handled as one or two 32-bit little-endian word operations. The outgoing write uses a valid/ready handshake. The block holds address and data steady for as long as the receiver applies back-pressure (ready low). Notifications that arrive while a write is outstanding are not lost. They are kept as per-vector pending bits and served later, lowest vector first.

Top module: `irq_msg_deliver`

## Requirements
- R1: After reset, `msi_valid`, `irq_wire` and `reg_ack` are low, and every table word and every pending-array word reads as zero.
- R2: Entry n of the table occupies 16 bytes at TBL_BASE + 16n. Word 0 is the address low half, word 1 the address high half, word 2 the message data, word 3 a control word. A 4-byte read of a table word returns the last value written there in `reg_rdata[31:0]`, with `reg_rdata[63:32]` zero.
- R3: A 4-byte access is acknowledged with a one-cycle `reg_ack` pulse on the first cycle after the request is sampled. An 8-byte access at byte address A runs word A, then word A+4, and is acknowledged one cycle later. Its `reg_wdata[31:0]`/`reg_rdata[31:0]` belong to word A and bits 63:32 to word A+4.
- R4: A word address outside both the table and the pending array reads as zero, and a write there changes no table word.
- R5: The pending array starts at TBL_BASE + 256 and holds the vector count rounded up to 64 bits (two words). Bit n of its first word is the pending bit of vector n, and all other bits read zero. Writes to it have no effect.
- R6: With `wired_mode` high, a notification for vector n < 4 drives `irq_wire[n]` high for exactly one cycle. The pulse starts on the cycle after the notification is sampled. Vector 4 raises no line, and no memory write is issued in this mode.
- R7: With `wired_mode` low, a notification for vector n produces exactly one write with `msi_addr` = {word 1, word 0} and `msi_data` = word 2 of entry n. No wired line moves.
- R8: While `msi_valid` is high and `msi_ready` is low, `msi_valid`, `msi_addr` and `msi_data` stay unchanged, even if software rewrites the table entry meanwhile.
- R9: Message-mode notifications set the vector's pending bit. When no write is outstanding, the lowest-indexed pending vector is launched. A pending bit clears on the cycle its write is accepted.
- R10: A notification whose vector index is 5 or more is dropped: no line pulse, no write, no pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ntf_valid | input | 1 | Notification strobe, one cycle per notification |
| ntf_vec | input | VEC_W | Vector index of the notification |
| wired_mode | input | 1 | 1: wired line delivery, 0: message write delivery |
| reg_req | input | 1 | Register access request, held until `reg_ack` |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_wide | input | 1 | 1 for 8-byte access, 0 for 4-byte |
| reg_addr | input | AW | Byte address of the access |
| reg_wdata | input | 64 | Write data, low word in bits 31:0 |
| reg_ack | output | 1 | One-cycle completion pulse |
| reg_rdata | output | 64 | Read data, valid while `reg_ack` is high |
| irq_wire | output | N_WIRE | Wired interrupt lines, one-cycle pulses |
| msi_valid | output | 1 | Outgoing write request valid |
| msi_ready | input | 1 | Receiver accepts the write when high with valid |
| msi_addr | output | 64 | Target address of the write |
| msi_data | output | 32 | Payload of the write |

## Verification
The bench goes after the pending-order corner. Four notifications arrive while the first write is stalled, and the writes must come out in vector order 3, 0, 1, 4. A design that served them by arrival order, or that cleared a bit on launch instead of on acceptance, shows the wrong order or a wrong pending-array value. It rewrites a table entry in the middle of a stall. A design that read the table live would change `msi_addr` under back-pressure. It sweeps every vector index, including 4 and 5 to 7, in both modes: a decoder that did not bound the index would pulse a nonexistent line or emit a write from garbage. It also writes to addresses just past the table and to the pending array. Each of these writes must leave all twenty table words unchanged.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned ENTRY_WORDS = 4;
  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned PBA_GAP     = 256;
  localparam int unsigned W_ADDR_LO   = 0;
  localparam int unsigned W_ADDR_HI   = 1;
  localparam int unsigned W_DATA      = 2;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msi_msg_t;
endpackage

// File: rtl/irqd_vec_table.sv
module irqd_vec_table
  import irqd_pkg::*;
#(
  parameter int unsigned N_VEC    = 5,
  parameter int unsigned AW       = 12,
  parameter int unsigned TBL_BASE = 'h300,
  parameter int unsigned IDXW     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_req,
  input  logic             reg_we,
  input  logic             reg_wide,
  input  logic [AW-1:0]    reg_addr,
  input  logic [63:0]      reg_wdata,
  input  logic [N_VEC-1:0] pend_bits,
  output logic             reg_ack,
  output logic [63:0]      reg_rdata,
  input  logic [IDXW-1:0]  rd_idx,
  output msi_msg_t         rd_msg
);
  localparam int unsigned TBL_WORDS = N_VEC * ENTRY_WORDS;
  localparam int unsigned PBA_BITS  = ((N_VEC + 63) / 64) * 64;
  localparam int unsigned PBA_WORDS = PBA_BITS / 32;
  localparam logic [AW-1:0] TBL_LO = AW'(TBL_BASE);
  localparam logic [AW-1:0] TBL_HI = AW'(TBL_BASE + TBL_WORDS * WORD_BYTES);
  localparam logic [AW-1:0] PBA_LO = AW'(TBL_BASE + PBA_GAP);
  localparam logic [AW-1:0] PBA_HI = AW'(TBL_BASE + PBA_GAP + PBA_WORDS * WORD_BYTES);

  logic [31:0]         tbl [TBL_WORDS];
  logic                phase;
  logic                ack_q;
  logic [63:0]         rdata_q;
  logic [AW-1:0]       op_addr;
  logic [AW-1:0]       tbl_wofs;
  logic [AW-1:0]       pba_wofs;
  logic                in_tbl;
  logic                in_pba;
  logic [31:0]         rd_word;
  logic [31:0]         wr_lane;
  logic [PBA_BITS-1:0] pba_vec;
  logic                step;
  logic                last;

  // word address of the current 32-bit operation; second half of a wide access is +4
  assign op_addr  = (reg_addr & ~AW'(3)) + (phase ? AW'(WORD_BYTES) : AW'(0));
  assign in_tbl   = (op_addr >= TBL_LO) && (op_addr < TBL_HI);
  assign in_pba   = (op_addr >= PBA_LO) && (op_addr < PBA_HI);
  assign tbl_wofs = (op_addr - TBL_LO) >> 2;
  assign pba_wofs = (op_addr - PBA_LO) >> 2;
  assign pba_vec  = PBA_BITS'(pend_bits);
  assign wr_lane  = phase ? reg_wdata[63:32] : reg_wdata[31:0];
  assign step     = reg_req && !ack_q;
  assign last     = !reg_wide || phase;

  always_comb begin
    rd_word = '0;
    if (in_tbl) begin
      for (int i = 0; i < TBL_WORDS; i++)
        if (tbl_wofs == AW'(i)) rd_word = tbl[i];
    end else if (in_pba) begin
      for (int k = 0; k < PBA_WORDS; k++)
        if (pba_wofs == AW'(k)) rd_word = pba_vec[32*k +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= 1'b0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
      for (int i = 0; i < TBL_WORDS; i++) tbl[i] <= '0;
    end else begin
      ack_q <= 1'b0;
      if (step) begin
        if (reg_we && in_tbl) begin
          for (int i = 0; i < TBL_WORDS; i++)
            if (tbl_wofs == AW'(i)) tbl[i] <= wr_lane;
        end
        if (phase) rdata_q[63:32] <= rd_word;
        else       rdata_q        <= {32'h0, rd_word};
        if (last) begin
          ack_q <= 1'b1;
          phase <= 1'b0;
        end else begin
          phase <= 1'b1;
        end
      end
    end
  end

  assign reg_ack   = ack_q;
  assign reg_rdata = rdata_q;

  always_comb begin
    rd_msg = '0;
    for (int e = 0; e < N_VEC; e++) begin
      if (rd_idx == IDXW'(e)) begin
        rd_msg.addr = {tbl[e*ENTRY_WORDS + W_ADDR_HI], tbl[e*ENTRY_WORDS + W_ADDR_LO]};
        rd_msg.data = tbl[e*ENTRY_WORDS + W_DATA];
      end
    end
  end
endmodule

// File: rtl/irqd_pend.sv
module irqd_pend #(
  parameter int unsigned N_VEC = 5,
  parameter int unsigned IDXW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDXW-1:0]  set_idx,
  input  logic             clr_en,
  input  logic [IDXW-1:0]  clr_idx,
  output logic [N_VEC-1:0] pend,
  output logic             any,
  output logic [IDXW-1:0]  pick_idx
);
  logic [N_VEC-1:0] set_hot;
  logic [N_VEC-1:0] clr_hot;

  for (genvar g = 0; g < N_VEC; g++) begin : g_dec
    assign set_hot[g] = set_en && (set_idx == IDXW'(g));
    assign clr_hot[g] = clr_en && (clr_idx == IDXW'(g));
  end

  // a new notification wins over a same-cycle acceptance of the same vector
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_hot) | set_hot;
  end

  always_comb begin
    any      = |pend;
    pick_idx = '0;
    for (int i = N_VEC - 1; i >= 0; i--)
      if (pend[i]) pick_idx = IDXW'(i);
  end
endmodule

// File: rtl/irqd_wire_pulse.sv
module irqd_wire_pulse #(
  parameter int unsigned N_WIRE = 4,
  parameter int unsigned VEC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [VEC_W-1:0]  vec,
  output logic [N_WIRE-1:0] lines
);
  logic [N_WIRE-1:0] hit;

  for (genvar g = 0; g < N_WIRE; g++) begin : g_line
    assign hit[g] = fire && (vec == VEC_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lines <= '0;
    else        lines <= hit;
  end
endmodule

// File: rtl/irqd_msi_out.sv
module irqd_msi_out
  import irqd_pkg::*;
#(
  parameter int unsigned IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic [IDXW-1:0] launch_idx,
  input  msi_msg_t        launch_msg,
  input  logic            ready,
  output logic            valid,
  output logic [63:0]     addr,
  output logic [31:0]     data,
  output logic [IDXW-1:0] cur_idx,
  output logic            accept
);
  msi_msg_t msg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      msg_q   <= '0;
      cur_idx <= '0;
    end else if (launch) begin
      valid   <= 1'b1;
      msg_q   <= launch_msg;
      cur_idx <= launch_idx;
    end else if (valid && ready) begin
      valid   <= 1'b0;
    end
  end

  assign accept = valid && ready;
  assign addr   = msg_q.addr;
  assign data   = msg_q.data;
endmodule

// File: rtl/irq_msg_deliver.sv
module irq_msg_deliver
  import irqd_pkg::*;
#(
  parameter int unsigned N_VEC    = 5,
  parameter int unsigned N_WIRE   = 4,
  parameter int unsigned VEC_W    = 3,
  parameter int unsigned AW       = 12,
  parameter int unsigned TBL_BASE = 'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ntf_valid,
  input  logic [VEC_W-1:0]  ntf_vec,
  input  logic              wired_mode,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic              reg_wide,
  input  logic [AW-1:0]     reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic              reg_ack,
  output logic [63:0]       reg_rdata,
  output logic [N_WIRE-1:0] irq_wire,
  output logic              msi_valid,
  input  logic              msi_ready,
  output logic [63:0]       msi_addr,
  output logic [31:0]       msi_data
);
  localparam int unsigned IDXW = (N_VEC > 1) ? $clog2(N_VEC) : 1;

  logic             in_range;
  logic             set_en;
  logic [N_VEC-1:0] pend;
  logic             any_pend;
  logic [IDXW-1:0]  pick_idx;
  logic [IDXW-1:0]  cur_idx;
  logic             accept;
  logic             launch;
  msi_msg_t         sel_msg;

  assign in_range = ntf_vec < VEC_W'(N_VEC);
  assign set_en   = ntf_valid && !wired_mode && in_range;
  assign launch   = !msi_valid && any_pend;

  irqd_vec_table #(
    .N_VEC(N_VEC), .AW(AW), .TBL_BASE(TBL_BASE), .IDXW(IDXW)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_we(reg_we), .reg_wide(reg_wide),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pend_bits(pend),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .rd_idx(pick_idx), .rd_msg(sel_msg)
  );

  irqd_pend #(.N_VEC(N_VEC), .IDXW(IDXW)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_en), .set_idx(IDXW'(ntf_vec)),
    .clr_en(accept), .clr_idx(cur_idx),
    .pend(pend), .any(any_pend), .pick_idx(pick_idx)
  );

  irqd_wire_pulse #(.N_WIRE(N_WIRE), .VEC_W(VEC_W)) u_wire (
    .clk(clk), .rst_n(rst_n),
    .fire(ntf_valid && wired_mode), .vec(ntf_vec),
    .lines(irq_wire)
  );

  irqd_msi_out #(.IDXW(IDXW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .launch_idx(pick_idx), .launch_msg(sel_msg),
    .ready(msi_ready), .valid(msi_valid),
    .addr(msi_addr), .data(msi_data),
    .cur_idx(cur_idx), .accept(accept)
  );
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
  parameter int unsigned N_VEC  = 5,
  parameter int unsigned N_WIRE = 4,
  parameter int unsigned VEC_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ntf_valid,
  input logic [VEC_W-1:0]  ntf_vec,
  input logic              wired_mode,
  input logic              reg_ack,
  input logic [N_WIRE-1:0] irq_wire,
  input logic              msi_valid,
  input logic              msi_ready,
  input logic [63:0]       msi_addr,
  input logic [31:0]       msi_data
);
  // R8: back-pressure freezes the outgoing write
  p_hold_under_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && !msi_ready) |=> (msi_valid && $stable(msi_addr) && $stable(msi_data)));

  // R6: at most one wired line at a time
  p_wire_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_wire));

  // R6/R7: a line pulse needs a wired-mode notification on the cycle before
  p_wire_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_wire != '0) |-> $past(ntf_valid && wired_mode));

  // R6: vector 4 and above raise no line
  p_wire_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ntf_vec >= VEC_W'(N_WIRE)) |-> (irq_wire == '0));

  // R10: out-of-range vectors leave the lines quiet
  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ntf_valid && (ntf_vec >= VEC_W'(N_VEC))) |-> (irq_wire == '0));

  // R3: acknowledge is a single-cycle pulse
  p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ack |=> !reg_ack);
endmodule

bind irq_msg_deliver irqd_checker #(
  .N_VEC(N_VEC), .N_WIRE(N_WIRE), .VEC_W(VEC_W)
) u_irqd_chk (
  .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_vec(ntf_vec),
  .wired_mode(wired_mode), .reg_ack(reg_ack), .irq_wire(irq_wire),
  .msi_valid(msi_valid), .msi_ready(msi_ready),
  .msi_addr(msi_addr), .msi_data(msi_data)
);

// File: tb/irq_msg_deliver_bench.sv
module irq_msg_deliver_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 5;
  localparam int N_WIRE     = 4;
  localparam int AW         = 12;
  localparam int TBL_BASE   = 'h300;
  localparam int PBA_BASE   = TBL_BASE + 256;
  localparam int TBL_WORDS  = N_VEC * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ntf_valid = 1'b0;
  logic [2:0]    ntf_vec = '0;
  logic          wired_mode = 1'b0;
  logic          reg_req = 1'b0;
  logic          reg_we = 1'b0;
  logic          reg_wide = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [63:0]   reg_wdata = '0;
  logic          reg_ack;
  logic [63:0]   reg_rdata;
  logic [N_WIRE-1:0] irq_wire;
  logic          msi_valid;
  logic          msi_ready = 1'b0;
  logic [63:0]   msi_addr;
  logic [31:0]   msi_data;

  irq_msg_deliver u_irq_msg_deliver (
    .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_vec(ntf_vec),
    .wired_mode(wired_mode), .reg_req(reg_req), .reg_we(reg_we),
    .reg_wide(reg_wide), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata), .irq_wire(irq_wire),
    .msi_valid(msi_valid), .msi_ready(msi_ready),
    .msi_addr(msi_addr), .msi_data(msi_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_tbl [TBL_WORDS];
  logic [63:0] cap_addr [64];
  logic [31:0] cap_data [64];
  int ncap = 0;
  int wpulses = 0;
  int stab_err = 0;
  logic prev_stall = 1'b0;
  logic [63:0] prev_a = '0;
  logic [31:0] prev_d = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i, input int salt);
    logic [31:0] v;
    v = 32'(i + 3 + salt) * 32'h9E37_79B9;
    return v ^ 32'h5A5A_0000;
  endfunction

  // sampler just ahead of each rising edge, after the negedge drives settle
  always begin
    @(negedge clk);
    #(CLK_PERIOD/2 - 1);
    if (rst_n) begin
      if (prev_stall && (!msi_valid || msi_addr != prev_a || msi_data != prev_d))
        stab_err++;
      if (msi_valid && msi_ready && ncap < 64) begin
        cap_addr[ncap] = msi_addr;
        cap_data[ncap] = msi_data;
        ncap++;
      end
      if (irq_wire != '0) wpulses++;
      prev_stall = msi_valid && !msi_ready;
      prev_a = msi_addr;
      prev_d = msi_data;
    end
  end

  task automatic reg_op(input bit we, input bit wide, input int a,
                        input logic [63:0] wd, output logic [63:0] rd, output int lat);
    @(negedge clk);
    reg_req = 1'b1; reg_we = we; reg_wide = wide;
    reg_addr = AW'(a); reg_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!reg_ack && lat < 10);
    rd = reg_rdata;
    reg_req = 1'b0; reg_we = 1'b0; reg_wide = 1'b0;
  endtask

  task automatic notify(input int v);
    @(negedge clk);
    ntf_valid = 1'b1; ntf_vec = 3'(v);
    @(negedge clk);
    ntf_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_table(input string req);
    logic [63:0] rd; int lat;
    for (int i = 0; i < TBL_WORDS; i++) begin
      reg_op(1'b0, 1'b0, TBL_BASE + 4*i, '0, rd, lat);
      chk(rd == {32'h0, exp_tbl[i]}, req, $sformatf("table word %0d", i), rd, {32'h0, exp_tbl[i]});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    int lat;
    int base;
    logic [63:0] ea;

    for (int i = 0; i < TBL_WORDS; i++) exp_tbl[i] = '0;
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    chk(msi_valid == 1'b0, "R1", "msi_valid", 64'(msi_valid), 64'h0);
    chk(irq_wire == '0, "R1", "irq_wire", 64'(irq_wire), 64'h0);
    chk(reg_ack == 1'b0, "R1", "reg_ack", 64'(reg_ack), 64'h0);
    check_table("R1");
    reg_op(1'b0, 1'b1, PBA_BASE, '0, rd, lat);
    chk(rd == 64'h0, "R1", "pending array", rd, 64'h0);

    // R2, R3: narrow writes then narrow and wide readback
    for (int i = 0; i < TBL_WORDS; i++) begin
      exp_tbl[i] = pat(i, 0);
      reg_op(1'b1, 1'b0, TBL_BASE + 4*i, {32'hDEAD_BEEF, exp_tbl[i]}, rd, lat);
      chk(lat == 1, "R3", "narrow ack latency", 64'(lat), 64'd1);
    end
    check_table("R2");
    for (int k = 0; k < TBL_WORDS/2; k++) begin
      reg_op(1'b0, 1'b1, TBL_BASE + 8*k, '0, rd, lat);
      chk(rd == {exp_tbl[2*k+1], exp_tbl[2*k]}, "R3", $sformatf("wide read pair %0d", k),
          rd, {exp_tbl[2*k+1], exp_tbl[2*k]});
      chk(lat == 2, "R3", "wide ack latency", 64'(lat), 64'd2);
    end
    // R3: wide writes split low word first
    for (int e = 0; e < N_VEC; e++) begin
      exp_tbl[4*e]   = pat(e, 40);
      exp_tbl[4*e+1] = pat(e, 80);
      reg_op(1'b1, 1'b1, TBL_BASE + 16*e, {exp_tbl[4*e+1], exp_tbl[4*e]}, rd, lat);
    end
    check_table("R3");

    // R4: out-of-range accesses
    reg_op(1'b1, 1'b0, TBL_BASE + 4*TBL_WORDS, 64'hFFFF_FFFF, rd, lat);
    reg_op(1'b1, 1'b0, TBL_BASE - 4, 64'hFFFF_FFFF, rd, lat);
    reg_op(1'b1, 1'b1, PBA_BASE + 8, 64'hFFFF_FFFF_FFFF_FFFF, rd, lat);
    reg_op(1'b0, 1'b0, TBL_BASE + 4*TBL_WORDS, '0, rd, lat);
    chk(rd == 64'h0, "R4", "read past table", rd, 64'h0);
    reg_op(1'b0, 1'b1, PBA_BASE + 8, '0, rd, lat);
    chk(rd == 64'h0, "R4", "read past pending array", rd, 64'h0);
    // R5: pending array writes have no effect
    reg_op(1'b1, 1'b1, PBA_BASE, 64'hFFFF_FFFF_FFFF_FFFF, rd, lat);
    reg_op(1'b0, 1'b1, PBA_BASE, '0, rd, lat);
    chk(rd == 64'h0, "R5", "pending array after write", rd, 64'h0);
    check_table("R4");

    // R6, R10: wired sweep over every encodable index
    wired_mode = 1'b1;
    msi_ready  = 1'b1;
    for (int v = 0; v < 8; v++) begin
      logic [N_WIRE-1:0] ew;
      ew = (v < N_WIRE) ? N_WIRE'(1 << v) : '0;
      base = ncap;
      notify(v);
      chk(irq_wire == ew, (v < N_VEC) ? "R6" : "R10", $sformatf("pulse vec %0d", v),
          64'(irq_wire), 64'(ew));
      @(negedge clk);
      chk(irq_wire == '0, "R6", $sformatf("pulse width vec %0d", v), 64'(irq_wire), 64'h0);
      idle(4);
      chk(ncap == base, "R6", "no write in wired mode", 64'(ncap - base), 64'h0);
    end

    // R7, R10: message sweep with ready held high
    wired_mode = 1'b0;
    base = wpulses;
    for (int v = 0; v < 8; v++) begin
      int c0;
      c0 = ncap;
      notify(v);
      idle(6);
      if (v < N_VEC) begin
        ea = {exp_tbl[4*v+1], exp_tbl[4*v]};
        chk(ncap == c0 + 1, "R7", $sformatf("write count vec %0d", v), 64'(ncap - c0), 64'd1);
        chk(cap_addr[c0] == ea, "R7", $sformatf("address vec %0d", v), cap_addr[c0], ea);
        chk(cap_data[c0] == exp_tbl[4*v+2], "R7", $sformatf("data vec %0d", v),
            64'(cap_data[c0]), 64'(exp_tbl[4*v+2]));
      end else begin
        chk(ncap == c0, "R10", $sformatf("dropped vec %0d", v), 64'(ncap - c0), 64'h0);
        reg_op(1'b0, 1'b0, PBA_BASE, '0, rd, lat);
        chk(rd == 64'h0, "R10", "no pending bit", rd, 64'h0);
      end
    end
    chk(wpulses == base, "R7", "no wired pulse in message mode", 64'(wpulses - base), 64'h0);

    // R8: stall while software rewrites the entry
    msi_ready = 1'b0;
    base = ncap;
    ea = {exp_tbl[9], exp_tbl[8]};
    notify(2);
    idle(2);
    chk(msi_valid == 1'b1, "R8", "valid while stalled", 64'(msi_valid), 64'd1);
    exp_tbl[8] = 32'h0BAD_F00D;
    reg_op(1'b1, 1'b0, TBL_BASE + 32, {32'h0, exp_tbl[8]}, rd, lat);
    idle(3);
    chk(msi_addr == ea, "R8", "address held", msi_addr, ea);
    chk(msi_data == exp_tbl[10], "R8", "data held", 64'(msi_data), 64'(exp_tbl[10]));
    msi_ready = 1'b1;
    idle(3);
    chk(ncap == base + 1 && cap_addr[base] == ea, "R8", "accepted value", cap_addr[base], ea);
    chk(stab_err == 0, "R8", "stall stability", 64'(stab_err), 64'h0);

    // R9, R5: pending order under back-pressure
    msi_ready = 1'b0;
    base = ncap;
    notify(3);
    notify(1);
    notify(4);
    notify(0);
    notify(6);
    idle(2);
    reg_op(1'b0, 1'b0, PBA_BASE, '0, rd, lat);
    chk(rd == 64'h1B, "R5", "pending bits narrow", rd, 64'h1B);
    reg_op(1'b0, 1'b1, PBA_BASE, '0, rd, lat);
    chk(rd == 64'h1B, "R9", "pending bits wide", rd, 64'h1B);
    msi_ready = 1'b1;
    idle(20);
    chk(ncap == base + 4, "R9", "write count", 64'(ncap - base), 64'd4);
    begin
      int order [4] = '{3, 0, 1, 4};
      for (int j = 0; j < 4; j++) begin
        int v;
        v  = order[j];
        ea = {exp_tbl[4*v+1], exp_tbl[4*v]};
        chk(cap_addr[base+j] == ea && cap_data[base+j] == exp_tbl[4*v+2], "R9",
            $sformatf("order slot %0d vec %0d", j, v), cap_addr[base+j], ea);
      end
    end
    reg_op(1'b0, 1'b0, PBA_BASE, '0, rd, lat);
    chk(rd == 64'h0, "R9", "pending cleared on acceptance", rd, 64'h0);
    chk(stab_err == 0, "R8", "stability over order test", 64'(stab_err), 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule